// File: doc/BRIEF.md
# Two-Level Interrupt Entry Sequencer

This block sits beside a small 16-bit processor core. It owns the interrupt side of the program counter, the status word and the stack pointer. Eight normal request lines share one priority level. One fast request line forms a second level. Each level keeps an enable bit and an in-service bit. A request is taken only when its level is enabled and idle. A fast service in progress also holds off every normal request.

When a request is taken, the block runs a fixed entry sequence on a word-addressed memory port:
- write PC at SP, then decrement SP;
- write SR at SP, then decrement SP;
- read the vector word, load PC from it and clear SR.

A return strobe runs the mirror sequence, then re-issues the lowest-numbered request that was held back while it could not be taken. Enable commands arrive as 4-bit codes. The core may hand over new PC, SR and SP values while the block is idle.

The controller is a state machine with seven states:
- BOOT fetches the reset vector, then goes to IDLE.
- IDLE goes to PUSH_PC when a request is accepted, and to POP_SR on a return strobe.
- PUSH_PC goes to PUSH_SR.
- PUSH_SR goes to VEC.
- VEC goes back to IDLE.
- POP_SR goes to POP_PC.
- POP_PC goes back to IDLE.

Every step out of a memory state waits for a completed handshake (`mem_req` and `mem_ready` both high at a clock edge).

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is active and after it, both enable bits, both in-service bits and all held requests are clear, and PC, SR and SP are zero. The block then reads word 0xFFF7 and loads PC from the data. `busy` stays high until that read completes.
- R2: A command with `en_cmd_valid` high changes only the enable bits, as follows:
  - code 0: both off;
  - code 1: normal on, fast off;
  - code 2: normal off, fast on;
  - code 3: both on;
  - code 8: normal off;
  - code 9: normal on;
  - code 12: fast off;
  - code 13: fast on;
  - any other code: no change.
  `irq_state` and `fiq_state` each show bit 0 as enable and bit 1 as in-service.
- R3: A normal request is accepted only when the normal state is exactly enabled-and-not-in-service and the fast level is not in service. Otherwise no memory access starts and the line is held as pending.
- R4: The fast request is accepted only when the fast state is exactly enabled-and-not-in-service. When fast and normal requests are waiting together, the fast one is evaluated first.
- R5: The entry sequence runs in this order:
  - write PC at SP, then SP is decremented;
  - write SR at SP, then SP is decremented;
  - read the vector word, load PC from it and set SR to zero.
  `busy` is high throughout. The in-service bit of the accepted level is set on acceptance.
- R6: Normal line n vectors through word 0xFFF8+n. The fast line vectors through word 0xFFF6.
- R7: A return strobe in IDLE runs the return sequence:
  - read word SP+1 into SR, then SP is incremented;
  - read word SP+1 into PC, then SP is incremented.
  It then clears the fast in-service bit if it is set, otherwise the normal in-service bit.
- R8: When a return completes, the pending mark of the line being served is cleared. Among the other pending lines, the lowest index is chosen, scanning normal lines 0..7 and then the fast line as index 8. That line's pending mark is cleared and it is requested again, going through normal acceptance.
- R9: Deasserting a line removes its pending mark and any unserved request from it, so it is never replayed.
- R10: A request is raised by a low-to-high change on a line. A line held high does not request again. A change seen while `busy` is high waits until IDLE.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R12: `ctx_wr` loads PC, SR and SP from `ctx_pc`, `ctx_sr` and `ctx_sp` only in IDLE. While `busy` is high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_IRQ | Normal request lines, index = line number |
| fiq_line | input | 1 | Fast request line |
| en_cmd_valid | input | 1 | Enable command strobe |
| en_cmd | input | 4 | Enable command code |
| ret_strobe | input | 1 | Return-from-interrupt pulse, honoured in IDLE |
| ctx_wr | input | 1 | Load PC, SR and SP from the core |
| ctx_pc | input | DW | PC value to load |
| ctx_sr | input | DW | SR value to load |
| ctx_sp | input | AW | SP value to load |
| busy | output | 1 | High outside IDLE |
| pc_o | output | DW | Current PC |
| sr_o | output | DW | Current SR |
| sp_o | output | AW | Current SP |
| irq_state | output | 2 | Normal level: bit1 in service, bit0 enable |
| fiq_state | output | 2 | Fast level: bit1 in service, bit0 enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge when mem_req is high |

## Verification
The bench builds the block with its default parameters: eight normal lines, 16-bit words, and vectors at 0xFFF6, 0xFFF7 and 0xFFF8 upward. These defaults reach every vector slot the tests use, including the fast vector and the reset fetch. A 16-bit SP makes push and pop addresses exact values the scoreboard can predict. The bench memory inserts zero or two wait cycles, so both the single-cycle handshake and the held-request case are covered. Nested blocking, replay order and fast-before-normal ordering follow from these defaults.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VEC,
        ST_POP_SR,
        ST_POP_PC
    } seq_state_e;

    localparam logic [3:0] CMD_BOTH_OFF = 4'd0;
    localparam logic [3:0] CMD_IRQ_ONLY = 4'd1;
    localparam logic [3:0] CMD_FIQ_ONLY = 4'd2;
    localparam logic [3:0] CMD_BOTH_ON  = 4'd3;
    localparam logic [3:0] CMD_IRQ_OFF  = 4'd8;
    localparam logic [3:0] CMD_IRQ_ON   = 4'd9;
    localparam logic [3:0] CMD_FIQ_OFF  = 4'd12;
    localparam logic [3:0] CMD_FIQ_ON   = 4'd13;

endpackage

// File: rtl/isq_line_edge.sv
module isq_line_edge #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall,
    output logic [N-1:0] prev_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
    assign fall = ~lines & prev_q;
endmodule

// File: rtl/isq_pick.sv
module isq_pick #(
    parameter int N          = 9,
    parameter bit FAST_FIRST = 1'b0,
    localparam int IW        = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    generate
        if (FAST_FIRST) begin : g_fast
            always_comb begin
                found = 1'b0;
                idx   = '0;
                for (int i = N - 2; i >= 0; i--) begin
                    if (req[i]) begin
                        found = 1'b1;
                        idx   = IW'(i);
                    end
                end
                if (req[N-1]) begin
                    found = 1'b1;
                    idx   = IW'(N - 1);
                end
            end
        end else begin : g_plain
            always_comb begin
                found = 1'b0;
                idx   = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        found = 1'b1;
                        idx   = IW'(i);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/isq_level_ctl.sv
module isq_level_ctl
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd,
    input  logic       take_irq,
    input  logic       take_fiq,
    input  logic       ret_done,
    output logic       irq_en,
    output logic       irq_isv,
    output logic       fiq_en,
    output logic       fiq_isv
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            fiq_en <= 1'b0;
        end else if (cmd_valid) begin
            case (cmd)
                CMD_BOTH_OFF: begin irq_en <= 1'b0; fiq_en <= 1'b0; end
                CMD_IRQ_ONLY: begin irq_en <= 1'b1; fiq_en <= 1'b0; end
                CMD_FIQ_ONLY: begin irq_en <= 1'b0; fiq_en <= 1'b1; end
                CMD_BOTH_ON:  begin irq_en <= 1'b1; fiq_en <= 1'b1; end
                CMD_IRQ_OFF:  irq_en <= 1'b0;
                CMD_IRQ_ON:   irq_en <= 1'b1;
                CMD_FIQ_OFF:  fiq_en <= 1'b0;
                CMD_FIQ_ON:   fiq_en <= 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_isv <= 1'b0;
            fiq_isv <= 1'b0;
        end else begin
            if (take_irq) irq_isv <= 1'b1;
            if (take_fiq) fiq_isv <= 1'b1;
            if (ret_done) begin
                if (fiq_isv) fiq_isv <= 1'b0;
                else         irq_isv <= 1'b0;
            end
        end
    end

    // R3: normal level enters service only if it was enabled and the fast level idle
    assert_irq_take_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_isv) |-> ($past(irq_en) && !$past(fiq_isv)));

    // R4: fast level enters service only if it was enabled
    assert_fiq_take_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_isv) |-> $past(fiq_en));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter logic [AW-1:0] VEC_FIQ   = 'hFFF6,
    parameter logic [AW-1:0] VEC_RESET = 'hFFF7,
    parameter logic [AW-1:0] VEC_IRQ0  = 'hFFF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic               fiq_line,
    input  logic               en_cmd_valid,
    input  logic [3:0]         en_cmd,
    input  logic               ret_strobe,
    input  logic               ctx_wr,
    input  logic [DW-1:0]      ctx_pc,
    input  logic [DW-1:0]      ctx_sr,
    input  logic [AW-1:0]      ctx_sp,
    output logic               busy,
    output logic [DW-1:0]      pc_o,
    output logic [DW-1:0]      sr_o,
    output logic [AW-1:0]      sp_o,
    output logic [1:0]         irq_state,
    output logic [1:0]         fiq_state,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ready
);
    localparam int NL      = NUM_IRQ + 1;
    localparam int IW      = $clog2(NL);
    localparam int FIQ_IDX = NUM_IRQ;
    localparam logic [NL-1:0] BIT0 = NL'(1);

    seq_state_e state_q, state_d;

    logic [DW-1:0] pc_q, sr_q;
    logic [AW-1:0] sp_q, vec_q;
    logic [NL-1:0] trig_q, pend_q, trig_d, pend_d;
    logic [IW-1:0] cur_q;
    logic          cur_vld_q;

    logic [NL-1:0] lines, rise, fall, line_prev;
    logic          evt_found, rep_found;
    logic [IW-1:0] evt_idx, rep_idx;
    logic [NL-1:0] evt_mask, rep_mask, cur_mask;
    logic          irq_en, irq_isv, fiq_en, fiq_isv;
    logic          in_idle, do_ret, do_eval, evt_is_fiq, evt_ok;
    logic          take, block, hs, ret_done, ctx_load;
    logic [AW-1:0] take_vec;

    assign lines = {fiq_line, irq_line};

    isq_line_edge #(.N(NL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (lines),
        .rise   (rise),
        .fall   (fall),
        .prev_q (line_prev)
    );

    isq_pick #(.N(NL), .FAST_FIRST(1'b1)) u_pick_evt (
        .req   (trig_q),
        .found (evt_found),
        .idx   (evt_idx)
    );

    assign cur_mask = cur_vld_q ? (BIT0 << cur_q) : '0;

    isq_pick #(.N(NL), .FAST_FIRST(1'b0)) u_pick_rep (
        .req   (pend_q & ~cur_mask),
        .found (rep_found),
        .idx   (rep_idx)
    );

    isq_level_ctl u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (en_cmd_valid),
        .cmd       (en_cmd),
        .take_irq  (take && !evt_is_fiq),
        .take_fiq  (take && evt_is_fiq),
        .ret_done  (ret_done),
        .irq_en    (irq_en),
        .irq_isv   (irq_isv),
        .fiq_en    (fiq_en),
        .fiq_isv   (fiq_isv)
    );

    // ---------------- arbitration ----------------
    assign in_idle    = (state_q == ST_IDLE);
    assign do_ret     = in_idle && ret_strobe;
    assign ctx_load   = in_idle && ctx_wr && !ret_strobe;
    assign do_eval    = in_idle && !ret_strobe && !ctx_wr && evt_found;
    assign evt_is_fiq = (evt_idx == IW'(FIQ_IDX));
    assign evt_ok     = evt_is_fiq ? (fiq_en && !fiq_isv)
                                   : (irq_en && !irq_isv && !fiq_isv);
    assign take       = do_eval && evt_ok;
    assign block      = do_eval && !evt_ok;
    assign hs         = mem_req && mem_ready;
    assign ret_done   = (state_q == ST_POP_PC) && hs;
    assign evt_mask   = BIT0 << evt_idx;
    assign rep_mask   = BIT0 << rep_idx;
    assign take_vec   = evt_is_fiq ? VEC_FIQ
                                   : VEC_IRQ0 + {{(AW-IW){1'b0}}, evt_idx};

    always_comb begin
        trig_d = trig_q | rise;
        if (ret_done && rep_found) trig_d = trig_d | rep_mask;
        if (do_eval)               trig_d = trig_d & ~evt_mask;
        trig_d = trig_d & ~fall;

        pend_d = pend_q;
        if (block)                 pend_d = pend_d | evt_mask;
        if (ret_done)              pend_d = pend_d & ~cur_mask;
        if (ret_done && rep_found) pend_d = pend_d & ~rep_mask;
        pend_d = pend_d & ~fall;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:    if (hs) state_d = ST_IDLE;
            ST_IDLE: begin
                if (do_ret)    state_d = ST_POP_SR;
                else if (take) state_d = ST_PUSH_PC;
            end
            ST_PUSH_PC: if (hs) state_d = ST_PUSH_SR;
            ST_PUSH_SR: if (hs) state_d = ST_VEC;
            ST_VEC:     if (hs) state_d = ST_IDLE;
            ST_POP_SR:  if (hs) state_d = ST_POP_PC;
            ST_POP_PC:  if (hs) state_d = ST_IDLE;
            default:    state_d = ST_BOOT;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = 1'b1;
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_BOOT:    mem_addr = VEC_RESET;
            ST_IDLE: begin
                busy    = 1'b0;
                mem_req = 1'b0;
            end
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q;
                mem_wdata = pc_q;
            end
            ST_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q;
                mem_wdata = sr_q;
            end
            ST_VEC:     mem_addr = vec_q;
            ST_POP_SR:  mem_addr = sp_q + AW'(1);
            ST_POP_PC:  mem_addr = sp_q + AW'(1);
            default: ;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            sr_q      <= '0;
            sp_q      <= '0;
            trig_q    <= '0;
            pend_q    <= '0;
            cur_q     <= '0;
            cur_vld_q <= 1'b0;
            vec_q     <= VEC_RESET;
        end else begin
            trig_q <= trig_d;
            pend_q <= pend_d;
            if (ctx_load) begin
                pc_q <= ctx_pc;
                sr_q <= ctx_sr;
                sp_q <= ctx_sp;
            end
            if (take) begin
                cur_q     <= evt_idx;
                cur_vld_q <= 1'b1;
                vec_q     <= take_vec;
            end
            if (hs) begin
                unique case (state_q)
                    ST_BOOT:    pc_q <= mem_rdata;
                    ST_PUSH_PC: sp_q <= sp_q - AW'(1);
                    ST_PUSH_SR: sp_q <= sp_q - AW'(1);
                    ST_VEC: begin
                        pc_q <= mem_rdata;
                        sr_q <= '0;
                    end
                    ST_POP_SR: begin
                        sp_q <= sp_q + AW'(1);
                        sr_q <= mem_rdata;
                    end
                    ST_POP_PC: begin
                        sp_q      <= sp_q + AW'(1);
                        pc_q      <= mem_rdata;
                        cur_vld_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pc_o      = pc_q;
    assign sr_o      = sr_q;
    assign sp_o      = sp_q;
    assign irq_state = {irq_isv, irq_en};
    assign fiq_state = {fiq_isv, fiq_en};

    // ---------------- assertions ----------------
    assert_push_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && mem_we) |=> (sp_q == $past(sp_q) - AW'(1)));

    assert_sr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && state_q == ST_VEC) |=> (sr_q == '0));

    assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (state_q == ST_POP_SR || state_q == ST_POP_PC)) |=> (sp_q == $past(sp_q) + AW'(1)));

    assert_pend_follow_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~line_prev) == '0);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_ctx_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hs) |=> $stable(sp_q));
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_line = '0;
    logic        fiq_line = 1'b0;
    logic        en_cmd_valid = 1'b0;
    logic [3:0]  en_cmd = '0;
    logic        ret_strobe = 1'b0;
    logic        ctx_wr = 1'b0;
    logic [15:0] ctx_pc = '0, ctx_sr = '0, ctx_sp = '0;
    logic        busy;
    logic [15:0] pc_o, sr_o, sp_o;
    logic [1:0]  irq_state, fiq_state;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .fiq_line(fiq_line),
        .en_cmd_valid(en_cmd_valid), .en_cmd(en_cmd), .ret_strobe(ret_strobe),
        .ctx_wr(ctx_wr), .ctx_pc(ctx_pc), .ctx_sr(ctx_sr), .ctx_sp(ctx_sp),
        .busy(busy), .pc_o(pc_o), .sr_o(sr_o), .sp_o(sp_o),
        .irq_state(irq_state), .fiq_state(fiq_state),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [15:0] mem_model [logic [15:0]];
    int          n_chk = 0;
    int          n_fail = 0;
    int          wait_cfg = 0;
    int          wcnt = 0;
    bit          have_hold = 0;
    logic [15:0] hold_addr, hold_wdata;
    logic        hold_we;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_val(input logic [15:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return a ^ 16'h5A5A;
    endfunction

    // driver side of the scoreboard
    task automatic exp_entry(input logic [15:0] pc, input logic [15:0] sr,
                             input logic [15:0] sp, input logic [15:0] vec);
        exp_q.push_back({1'b1, sp, pc});
        exp_q.push_back({1'b1, sp - 16'd1, sr});
        exp_q.push_back({1'b0, vec, 16'h0});
    endtask

    task automatic exp_return(input logic [15:0] sp);
        exp_q.push_back({1'b0, sp + 16'd1, 16'h0});
        exp_q.push_back({1'b0, sp + 16'd2, 16'h0});
    endtask

    // monitor + memory model
    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (rst_n && mem_req) begin
            if (have_hold) begin
                chk(mem_addr == hold_addr && mem_we == hold_we && mem_wdata == hold_wdata,
                    "R11 request held", mem_addr, hold_addr);
            end else begin
                have_hold  = 1;
                hold_addr  = mem_addr;
                hold_we    = mem_we;
                hold_wdata = mem_wdata;
            end
            if (wcnt >= wait_cfg) begin
                acc_t e;
                mem_ready = 1'b1;
                wcnt      = 0;
                have_hold = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected access", mem_addr, 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr, "R5 access kind/address", mem_addr, e.addr);
                    if (e.we) chk(mem_wdata == e.data, "R5 write data", mem_wdata, e.data);
                end
                if (mem_we) mem_model[mem_addr] = mem_wdata;
                else        mem_rdata = rd_val(mem_addr);
            end else begin
                wcnt++;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (busy) q = 0;
            else      q++;
        end
    endtask

    task automatic send_cmd(input logic [3:0] c);
        en_cmd_valid = 1'b1;
        en_cmd       = c;
        @(negedge clk);
        en_cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ret();
        ret_strobe = 1'b1;
        @(negedge clk);
        ret_strobe = 1'b0;
    endtask

    task automatic chk_lvl(input logic [1:0] ei, input logic [1:0] ef, input string tag);
        chk(irq_state == ei, tag, {14'h0, irq_state}, {14'h0, ei});
        chk(fiq_state == ef, tag, {14'h0, fiq_state}, {14'h0, ef});
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(3);
        chk(busy == 1'b1, "R1 busy in reset", {15'h0, busy}, 16'h1);
        chk(pc_o == 16'h0 && sp_o == 16'h0, "R1 regs zero", pc_o, 16'h0);
        chk_lvl(2'b00, 2'b00, "R1 levels clear");
        exp_q.push_back({1'b0, 16'hFFF7, 16'h0});
        rst_n = 1'b1;
        wait_quiet();
        chk(pc_o == (16'hFFF7 ^ 16'h5A5A), "R1 reset vector", pc_o, 16'hFFF7 ^ 16'h5A5A);
        chk(sr_o == 16'h0, "R1 SR zero", sr_o, 16'h0);

        // R12 context load in IDLE
        ctx_pc = 16'h1234; ctx_sr = 16'h00AB; ctx_sp = 16'h0800;
        ctx_wr = 1'b1; @(negedge clk); ctx_wr = 1'b0; @(negedge clk);
        chk(pc_o == 16'h1234 && sr_o == 16'h00AB && sp_o == 16'h0800, "R12 ctx load", sp_o, 16'h0800);

        // R2 enable codes
        send_cmd(4'd1);  chk_lvl(2'b01, 2'b00, "R2 code1");
        send_cmd(4'd2);  chk_lvl(2'b00, 2'b01, "R2 code2");
        send_cmd(4'd3);  chk_lvl(2'b01, 2'b01, "R2 code3");
        send_cmd(4'd0);  chk_lvl(2'b00, 2'b00, "R2 code0");
        send_cmd(4'd9);  chk_lvl(2'b01, 2'b00, "R2 code9");
        send_cmd(4'd13); chk_lvl(2'b01, 2'b01, "R2 code13");
        send_cmd(4'd5);  chk_lvl(2'b01, 2'b01, "R2 undefined code");
        send_cmd(4'd12); chk_lvl(2'b01, 2'b00, "R2 code12");
        send_cmd(4'd8);  chk_lvl(2'b00, 2'b00, "R2 code8");
        send_cmd(4'd3);

        // R5 R6 normal entry on line 2; R12 ctx ignored while busy
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFFA);
        irq_line[2] = 1'b1;
        cyc(2);
        chk(busy == 1'b1, "R5 busy during entry", {15'h0, busy}, 16'h1);
        ctx_sp = 16'h1111; ctx_wr = 1'b1; @(negedge clk); ctx_wr = 1'b0;
        wait_quiet();
        chk(pc_o == (16'hFFFA ^ 16'h5A5A), "R6 line2 vector", pc_o, 16'hFFFA ^ 16'h5A5A);
        chk(sr_o == 16'h0, "R5 SR cleared", sr_o, 16'h0);
        chk(sp_o == 16'h07FE, "R12 ctx ignored when busy", sp_o, 16'h07FE);
        chk_lvl(2'b11, 2'b01, "R5 in service set");

        // R3 R9 nested requests held; line 5 dropped
        irq_line[5] = 1'b1; cyc(2);
        irq_line[1] = 1'b1; cyc(2);
        chk(busy == 1'b0, "R3 blocked while in service", {15'h0, busy}, 16'h0);
        irq_line[5] = 1'b0; cyc(2);

        // R7 R8 return then replay of line 1
        exp_return(16'h07FE);
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFF9);
        pulse_ret();
        wait_quiet();
        chk(pc_o == (16'hFFF9 ^ 16'h5A5A), "R8 replay lowest pending", pc_o, 16'hFFF9 ^ 16'h5A5A);
        chk(sp_o == 16'h07FE, "R8 replay SP", sp_o, 16'h07FE);

        exp_return(16'h07FE);
        pulse_ret();
        wait_quiet();
        chk(pc_o == 16'h1234 && sr_o == 16'h00AB, "R7 PC/SR restored", pc_o, 16'h1234);
        chk(sp_o == 16'h0800, "R7 SP restored", sp_o, 16'h0800);
        chk_lvl(2'b01, 2'b01, "R7 in service cleared");
        chk(exp_q.size() == 0, "R9 dropped line not replayed", 16'(exp_q.size()), 16'h0);
        irq_line = '0; cyc(2);

        // R4 R6 fast entry, normal blocked, replay after fast return
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFF6);
        fiq_line = 1'b1;
        wait_quiet();
        chk(pc_o == (16'hFFF6 ^ 16'h5A5A), "R6 fast vector", pc_o, 16'hFFF6 ^ 16'h5A5A);
        chk_lvl(2'b01, 2'b11, "R4 fast in service");
        irq_line[0] = 1'b1; cyc(3);
        chk(busy == 1'b0, "R3 fast blocks normal", {15'h0, busy}, 16'h0);
        exp_return(16'h07FE);
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFF8);
        pulse_ret();
        wait_quiet();
        chk(pc_o == (16'hFFF8 ^ 16'h5A5A), "R8 replay after fast return", pc_o, 16'hFFF8 ^ 16'h5A5A);
        chk_lvl(2'b11, 2'b01, "R7 fast cleared first");
        exp_return(16'h07FE);
        pulse_ret();
        wait_quiet();
        fiq_line = 1'b0; irq_line = '0; cyc(2);

        // R4 R10 R11 simultaneous requests with wait states
        wait_cfg = 2;
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFF6);
        fiq_line = 1'b1; irq_line[3] = 1'b1;
        wait_quiet();
        chk(pc_o == (16'hFFF6 ^ 16'h5A5A), "R4 fast first", pc_o, 16'hFFF6 ^ 16'h5A5A);
        exp_return(16'h07FE);
        exp_entry(16'h1234, 16'h00AB, 16'h0800, 16'hFFFB);
        pulse_ret();
        wait_quiet();
        chk(pc_o == (16'hFFFB ^ 16'h5A5A), "R10 edge kept until idle", pc_o, 16'hFFFB ^ 16'h5A5A);
        exp_return(16'h07FE);
        pulse_ret();
        wait_quiet();
        chk(sp_o == 16'h0800 && pc_o == 16'h1234, "R11 wait-state return", sp_o, 16'h0800);
        fiq_line = 1'b0; irq_line = '0; cyc(2);

        // R3 R10 disabled request, then held level does not retrigger
        send_cmd(4'd0);
        irq_line[4] = 1'b1; cyc(6);
        chk(busy == 1'b0 && pc_o == 16'h1234, "R3 disabled no entry", pc_o, 16'h1234);
        send_cmd(4'd1); cyc(6);
        chk(busy == 1'b0 && pc_o == 16'h1234, "R10 level no retrigger", pc_o, 16'h1234);
        chk(exp_q.size() == 0, "R5 all accesses seen", 16'(exp_q.size()), 16'h0);

        summary();
        $finish;
    end
endmodule